// File: doc/BRIEF.md
# Two-Tone FSK Tag Waveform Generator

This block produces the 1-bit load-modulation sequence that a 125 kHz proximity tag uses when it answers with frequency-shift keying. Each half of a Manchester bit is a burst of one of two tones. The short tone is a cycle of 8 carrier periods with 2 periods loaded, repeated 6 times. The long tone is a cycle of 10 carrier periods with 3 periods loaded, repeated 5 times. Every pulse on the carrier strobe input moves the generator forward by exactly one sample.

A frame carries a 44-bit code. It opens with one lone short-tone cycle, which acts as a separator. A start marker follows, built from half-bits in a sequence that no valid Manchester bit can produce. The code bits then go out from the most significant bit down. A further lone separator cycle comes before each group of four bits. When the frame ends, it starts again at once and keeps repeating until the enable input drops. The code enters the block on two words. It is captured only at the first sample of a frame, and a high word that does not fit in 12 bits is refused.

The block sits between a carrier-recovery stage, which supplies the strobe, and an antenna-load driver, which takes the output.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: While reset is held and in the first cycle after it, `wave_out` is 0.
- R2: While `en` is low, `wave_out` is 0 and `tick` pulses have no effect. When `en` rises, the next tick emits sample 0 of a new frame.
- R3: Frame samples 0 to 7 are one lone short-tone cycle: 1,1,0,0,0,0,0,0. A short-tone cycle is always 2 ones followed by 6 zeros.
- R4: Samples 8 to 399 form the start marker. It is eight half-bits in the order short, short, short, long, long, long, short, long. A short half-bit is 6 short-tone cycles (48 samples). A long half-bit is 5 long-tone cycles of 1,1,1 followed by seven 0 (50 samples).
- R5: A code bit of 1 is a long half-bit followed by a short half-bit. A code bit of 0 is a short half-bit followed by a long half-bit.
- R6: Code bits follow the marker from bit 43 down to bit 0. One lone 8-sample short-tone cycle comes before every bit whose index mod 4 equals 3.
- R7: A frame is 4800 samples long. After the last sample, the next tick emits sample 0 of the next frame with no gap.
- R8: `wave_out` is registered. The sample for a tick appears in the cycle after the edge where `tick` is high, and it holds unchanged through cycles without a tick.
- R9: The code is taken from `code_hi`/`code_lo` only at the first sample of a frame. A change in the middle of a frame takes effect from the next frame.
- R10: A capture where `code_hi` has any bit set above bit 11 is refused, and the previously held code stays in use. After reset the held code is 0.
- R11: If `en` drops in the middle of a frame, `wave_out` reads 0 in the next cycle. Re-enabling starts again from sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears the sequencer and the output |
| tick | input | 1 | One-cycle strobe, one per carrier period |
| code_hi | input | 32 | Upper part of the code; only bits 11:0 may be set |
| code_lo | input | 32 | Lower 32 bits of the code |
| wave_out | output | 1 | Load-modulation sample, 1 = coil loaded |

## Verification
The bench builds the block with its default parameters: a 44-bit code, tones of 8 and 10 carrier periods with 6 and 5 repetitions, and groups of 4 bits. These values give the 4800-sample frame, so each check can walk a whole frame, its wrap into the next one, and both ends of the separator pattern, bits 43 and 0. Code values with alternating and constant bit patterns, the largest accepted high word and two refused ones are all compared sample by sample against a frame model in the bench.

// File: rtl/fsk_wave_pkg.sv
package fsk_wave_pkg;

  typedef enum logic [2:0] {
    SEG_LEAD   = 3'd0,
    SEG_MARK   = 3'd1,
    SEG_SEP    = 3'd2,
    SEG_HALF_A = 3'd3,
    SEG_HALF_B = 3'd4
  } seg_e;

  // loaded level of a tone cycle at a given phase
  function automatic logic tone_bit(input int unsigned phase, input int unsigned high_len);
    return phase < high_len;
  endfunction

  // a lone separator cycle precedes bits whose index is last-in-group
  function automatic logic sep_before(input int unsigned idx, input int unsigned group);
    return (idx % group) == (group - 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
  import fsk_wave_pkg::*;
#(
  parameter int SHORT_PER  = 8,
  parameter int SHORT_HIGH = 2,
  parameter int LONG_PER   = 10,
  parameter int LONG_HIGH  = 3,
  parameter int CYC_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic             long_sel,
  input  logic [CYC_W-1:0] reps,
  output logic             sample,
  output logic             seg_first,
  output logic             seg_last
);

  localparam int PH_W = $clog2(max2(SHORT_PER, LONG_PER));
  localparam logic [PH_W-1:0] SHORT_END = PH_W'(SHORT_PER - 1);
  localparam logic [PH_W-1:0] LONG_END  = PH_W'(LONG_PER - 1);

  logic [PH_W-1:0]  phase_q;
  logic [CYC_W-1:0] cyc_q;
  logic             cycle_end;

  assign cycle_end = (phase_q == (long_sel ? LONG_END : SHORT_END));
  assign seg_last  = cycle_end && (cyc_q == reps - CYC_W'(1));
  assign seg_first = (phase_q == '0) && (cyc_q == '0);
  assign sample    = tone_bit(32'(phase_q), long_sel ? 32'(LONG_HIGH) : 32'(SHORT_HIGH));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      phase_q <= '0;
      cyc_q   <= '0;
    end else if (tick) begin
      if (cycle_end) begin
        phase_q <= '0;
        cyc_q   <= seg_last ? '0 : cyc_q + CYC_W'(1);
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_wave_pkg::*;
#(
  parameter int                CODE_W    = 44,
  parameter int                GROUP     = 4,
  parameter int                SHORT_REP = 6,
  parameter int                LONG_REP  = 5,
  parameter int                MARK_LEN  = 8,
  parameter logic [MARK_LEN-1:0] MARK_LONG = 8'b1011_1000,
  parameter int                CYC_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  logic              seg_last,
  input  logic [CODE_W-1:0] code,
  output logic              long_sel,
  output logic [CYC_W-1:0]  reps,
  output logic              at_lead,
  output logic              frame_wrap
);

  localparam int MI_W = (MARK_LEN > 1) ? $clog2(MARK_LEN) : 1;
  localparam int BI_W = $clog2(CODE_W);
  localparam logic [MI_W-1:0] MARK_END = MI_W'(MARK_LEN - 1);
  localparam logic [BI_W-1:0] TOP_BIT  = BI_W'(CODE_W - 1);

  seg_e            seg_q;
  logic [MI_W-1:0] mark_q;
  logic [BI_W-1:0] bit_q;
  logic [BI_W-1:0] bit_next;
  logic            cur_bit;
  logic            adv;

  assign cur_bit  = code[bit_q];
  assign adv      = tick && seg_last;
  assign bit_next = bit_q - BI_W'(1);
  assign at_lead  = (seg_q == SEG_LEAD);
  assign frame_wrap = adv && (seg_q == SEG_HALF_B) && (bit_q == '0);

  always_comb begin
    unique case (seg_q)
      SEG_MARK:   long_sel = MARK_LONG[mark_q];
      SEG_HALF_A: long_sel = cur_bit;
      SEG_HALF_B: long_sel = ~cur_bit;
      default:    long_sel = 1'b0;
    endcase
    if (seg_q == SEG_LEAD || seg_q == SEG_SEP)
      reps = CYC_W'(1);
    else
      reps = long_sel ? CYC_W'(LONG_REP) : CYC_W'(SHORT_REP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      seg_q  <= SEG_LEAD;
      mark_q <= '0;
      bit_q  <= TOP_BIT;
    end else if (adv) begin
      unique case (seg_q)
        SEG_LEAD: begin
          seg_q  <= SEG_MARK;
          mark_q <= '0;
        end
        SEG_MARK: begin
          if (mark_q == MARK_END) begin
            bit_q <= TOP_BIT;
            seg_q <= sep_before(32'(TOP_BIT), 32'(GROUP)) ? SEG_SEP : SEG_HALF_A;
          end else begin
            mark_q <= mark_q + MI_W'(1);
          end
        end
        SEG_SEP:    seg_q <= SEG_HALF_A;
        SEG_HALF_A: seg_q <= SEG_HALF_B;
        SEG_HALF_B: begin
          if (bit_q == '0) begin
            seg_q <= SEG_LEAD;
            bit_q <= TOP_BIT;
          end else begin
            bit_q <= bit_next;
            seg_q <= sep_before(32'(bit_next), 32'(GROUP)) ? SEG_SEP : SEG_HALF_A;
          end
        end
        default: seg_q <= SEG_LEAD;
      endcase
    end
  end

endmodule

// File: rtl/fsk_code_latch.sv
module fsk_code_latch #(
  parameter int CODE_W  = 44,
  parameter int LO_W    = 32,
  parameter int HI_IN_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [HI_IN_W-1:0] code_hi,
  input  logic [LO_W-1:0]    code_lo,
  output logic               hi_bad,
  output logic [CODE_W-1:0]  code_q
);

  localparam int HI_W = CODE_W - LO_W;

  generate
    if (HI_IN_W > HI_W) begin : g_limit
      assign hi_bad = |code_hi[HI_IN_W-1:HI_W];
    end else begin : g_nolimit
      assign hi_bad = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      code_q <= '0;
    else if (load && !hi_bad)
      code_q <= {code_hi[HI_W-1:0], code_lo};
  end

endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen #(
  parameter int                  CODE_W     = 44,
  parameter int                  LO_W       = 32,
  parameter int                  HI_IN_W    = 32,
  parameter int                  SHORT_PER  = 8,
  parameter int                  SHORT_HIGH = 2,
  parameter int                  SHORT_REP  = 6,
  parameter int                  LONG_PER   = 10,
  parameter int                  LONG_HIGH  = 3,
  parameter int                  LONG_REP   = 5,
  parameter int                  GROUP      = 4,
  parameter int                  MARK_LEN   = 8,
  parameter logic [MARK_LEN-1:0] MARK_LONG  = 8'b1011_1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic [HI_IN_W-1:0] code_hi,
  input  logic [LO_W-1:0]    code_lo,
  output logic               wave_out
);

  localparam int MAX_REP = (SHORT_REP > LONG_REP) ? SHORT_REP : LONG_REP;
  localparam int CYC_W   = $clog2(MAX_REP + 1);

  logic              clear;
  logic              long_sel;
  logic [CYC_W-1:0]  reps;
  logic              sample;
  logic              tone_first;
  logic              seg_last;
  logic              at_lead;
  logic              frame_wrap;
  logic              load_evt;
  logic              hi_bad;
  logic [CODE_W-1:0] code_q;

  assign clear    = !en;
  assign load_evt = en && tick && at_lead && tone_first;

  fsk_tone_gen #(
    .SHORT_PER (SHORT_PER),
    .SHORT_HIGH(SHORT_HIGH),
    .LONG_PER  (LONG_PER),
    .LONG_HIGH (LONG_HIGH),
    .CYC_W     (CYC_W)
  ) u_tone (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .tick     (tick),
    .long_sel (long_sel),
    .reps     (reps),
    .sample   (sample),
    .seg_first(tone_first),
    .seg_last (seg_last)
  );

  fsk_frame_seq #(
    .CODE_W   (CODE_W),
    .GROUP    (GROUP),
    .SHORT_REP(SHORT_REP),
    .LONG_REP (LONG_REP),
    .MARK_LEN (MARK_LEN),
    .MARK_LONG(MARK_LONG),
    .CYC_W    (CYC_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .tick      (tick),
    .seg_last  (seg_last),
    .code      (code_q),
    .long_sel  (long_sel),
    .reps      (reps),
    .at_lead   (at_lead),
    .frame_wrap(frame_wrap)
  );

  fsk_code_latch #(
    .CODE_W (CODE_W),
    .LO_W   (LO_W),
    .HI_IN_W(HI_IN_W)
  ) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_evt),
    .code_hi(code_hi),
    .code_lo(code_lo),
    .hi_bad (hi_bad),
    .code_q (code_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !en)
      wave_out <= 1'b0;
    else if (tick)
      wave_out <= sample;
  end

endmodule

// File: rtl/fsk_tag_wavegen_chk.sv
module fsk_tag_wavegen_chk #(
  parameter int CODE_W = 44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              tick,
  input logic              wave_out,
  input logic              load_evt,
  input logic              hi_bad,
  input logic [CODE_W-1:0] code_q,
  input logic              frame_wrap,
  input logic              at_lead,
  input logic              tone_first
);

  // R2 / R11: disabled means a cleared output one cycle later
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wave_out);

  // R8: no tick, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(wave_out));

  // R8: a rising output needs a tick on the edge before
  p_rise_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave_out) |-> $past(tick));

  // R9: the held code moves only on a frame-start capture
  p_code_frame_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(code_q));

  // R10: an over-range high word leaves the held code alone
  p_reject_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && hi_bad) |=> $stable(code_q));

  // R7: the end of bit 0 leads straight back to the lead cycle
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && en) |=> (at_lead && tone_first));

endmodule

bind fsk_tag_wavegen fsk_tag_wavegen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .tick      (tick),
  .wave_out  (wave_out),
  .load_evt  (load_evt),
  .hi_bad    (hi_bad),
  .code_q    (code_q),
  .frame_wrap(frame_wrap),
  .at_lead   (at_lead),
  .tone_first(tone_first)
);

// File: tb/fsk_tag_wavegen_test.sv
module fsk_tag_wavegen_test;

  localparam int FRAME = 8 + 4 * 48 + 4 * 50 + 11 * 8 + 44 * 98;

  // {code_hi, code_lo, accepted}
  localparam logic [64:0] VEC [6] = '{
    {32'h0000_0ABC, 32'h1234_5678, 1'b1},
    {32'h0000_0000, 32'h0000_0000, 1'b1},
    {32'h0000_0FFF, 32'hFFFF_FFFF, 1'b1},
    {32'h0000_1000, 32'h5555_AAAA, 1'b0},
    {32'h8000_0000, 32'h0000_0000, 1'b0},
    {32'h0000_05A5, 32'h0F0F_F0F0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] code_hi = '0;
  logic [31:0] code_lo = '0;
  logic        wave_out;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fsk_tag_wavegen uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .tick    (tick),
    .code_hi (code_hi),
    .code_lo (code_lo),
    .wave_out(wave_out)
  );

  function automatic logic tone_at(input logic lng, input int m);
    return lng ? ((m % 10) < 3) : ((m % 8) < 2);
  endfunction

  // expected sample n of a frame carrying code c
  function automatic logic exp_at(input logic [43:0] c, input int n);
    int    m;
    int    len;
    logic  lng;
    logic [7:0] mk;
    mk = 8'b1011_1000;
    if (n < 8) return n < 2;
    m = n - 8;
    for (int h = 0; h < 8; h++) begin
      lng = mk[h];
      len = lng ? 50 : 48;
      if (m < len) return tone_at(lng, m);
      m -= len;
    end
    for (int b = 43; b >= 0; b--) begin
      if (b % 4 == 3) begin
        if (m < 8) return m < 2;
        m -= 8;
      end
      lng = c[b];
      len = lng ? 50 : 48;
      if (m < len) return tone_at(lng, m);
      m -= len;
      lng = !c[b];
      len = lng ? 50 : 48;
      if (m < len) return tone_at(lng, m);
      m -= len;
    end
    return 1'b0;
  endfunction

  function automatic string req_of(input int n);
    if (n < 8) return "R3";
    if (n < 400) return "R4";
    return "R5/R6";
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one tick; the sample is read at the following falling edge
  task automatic tick_once(output logic w);
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    w = wave_out;
  endtask

  task automatic run_frame(input logic [43:0] c, input int start, input int count,
                           input int gap, output int errs, output int bad_n,
                           output logic bad_act);
    logic w;
    errs = 0; bad_n = -1; bad_act = 1'b0;
    for (int k = 0; k < count; k++) begin
      tick_once(w);
      if (w !== exp_at(c, (start + k) % FRAME)) begin
        if (errs == 0) begin bad_n = (start + k) % FRAME; bad_act = w; end
        errs++;
      end
      for (int g = 0; g < gap; g++) begin
        @(posedge clk);
        @(negedge clk);
        if (wave_out !== w) begin
          if (errs == 0) begin bad_n = -2; bad_act = wave_out; end
          errs++;
        end
      end
    end
  endtask

  task automatic report(input string req, input int errs, input int bad_n,
                        input logic bad_act, input logic [43:0] c);
    string r;
    r = (bad_n >= 0) ? {req, " ", req_of(bad_n)} : req;
    check(errs == 0, r, int'(bad_act),
          (bad_n >= 0) ? int'(exp_at(c, bad_n)) : int'(!bad_act));
    if (errs != 0) $display("  first mismatch at sample %0d, %0d mismatches", bad_n, errs);
  endtask

  initial begin : watchdog
    for (int cyc = 0; cyc < 190000; cyc++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [43:0] cur;
    logic [43:0] nxt;
    int   errs;
    int   bad_n;
    logic bad_act;
    logic w;
    logic stuck;

    cur = '0;
    repeat (3) @(negedge clk);
    check(wave_out === 1'b0, "R1 in reset", int'(wave_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wave_out === 1'b0, "R1 after reset", int'(wave_out), 0);

    // R2: ticks while disabled do nothing
    stuck = 1'b0;
    for (int k = 0; k < 20; k++) begin
      tick_once(w);
      if (w !== 1'b0) stuck = 1'b1;
    end
    check(!stuck, "R2 disabled ticks", int'(stuck), 0);

    // table walk: one full frame per vector (R3..R6, R10)
    foreach (VEC[i]) begin
      en = 1'b0;
      @(negedge clk);
      code_hi = VEC[i][64:33];
      code_lo = VEC[i][32:1];
      if (VEC[i][0]) cur = {VEC[i][44:33], VEC[i][32:1]};
      en = 1'b1;
      run_frame(cur, 0, FRAME, 0, errs, bad_n, bad_act);
      report(VEC[i][0] ? "R3-R6 vector" : "R10 refused load", errs, bad_n, bad_act, cur);
    end

    // R7: continuous run wraps with no gap
    en = 1'b0;
    @(negedge clk);
    code_hi = 32'h0000_0C3A;
    code_lo = 32'hDEAD_BEEF;
    cur = {code_hi[11:0], code_lo};
    en = 1'b1;
    run_frame(cur, 0, 2 * FRAME, 0, errs, bad_n, bad_act);
    report("R7 two frames", errs, bad_n, bad_act, cur);

    // R9: mid-frame change applies from the next frame
    nxt = {12'h123, 32'h8765_4321};
    run_frame(cur, 0, 1000, 0, errs, bad_n, bad_act);
    code_hi = {20'h0, nxt[43:32]};
    code_lo = nxt[31:0];
    run_frame(cur, 1000, FRAME - 1000, 0, errs, bad_n, bad_act);
    report("R9 old code kept", errs, bad_n, bad_act, cur);
    run_frame(nxt, 0, FRAME, 0, errs, bad_n, bad_act);
    report("R9 new code next frame", errs, bad_n, bad_act, nxt);
    cur = nxt;

    // R11: disable mid-frame, then restart from sample 0
    run_frame(cur, 0, 2000, 0, errs, bad_n, bad_act);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(wave_out === 1'b0, "R11 cleared on disable", int'(wave_out), 0);
    en = 1'b1;
    run_frame(cur, 0, 600, 0, errs, bad_n, bad_act);
    report("R11 restart", errs, bad_n, bad_act, cur);

    // R8: sparse ticks, output held between them
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    run_frame(cur, 0, 500, 2, errs, bad_n, bad_act);
    report("R8 sparse ticks", errs, bad_n, bad_act, cur);

    // R8: one-cycle latency from the first tick
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check(wave_out === 1'b0, "R8 no tick yet", int'(wave_out), 0);
    tick_once(w);
    check(w === 1'b1, "R8 first sample", int'(w), 1);

    en = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule